// File: doc/BRIEF.md
# ADC Conversion Clock Divider with Cascaded Timebase Ticks

This block sits beside an analog-to-digital converter. From its parent clock it makes three enable pulses: a conversion-clock enable and two slower timebase ticks, one nominally every 10 microseconds and one nominally every millisecond. The ticks pace settling and sleep intervals. All three outputs are single-cycle enables in the parent clock domain, not generated clocks. The three stages form a cascade. The conversion enable divides the parent clock. The 10 µs tick divides the conversion enable. The millisecond tick divides the 10 µs tick.

Software writes one 32-bit word that holds three 8-bit divisor fields, each stored as its ratio minus one. Software also picks the field values and checks rate limits; this block does neither.

A small control state machine sequences the stages. CTL_IDLE is the reset state and emits no pulses. Any write moves the machine to CTL_LOAD: the write edge clears every counter, and CTL_LOAD holds all stages quiet for one cycle. From CTL_LOAD the machine moves to CTL_RUN on the next edge unless another write arrives. In CTL_RUN the first stage sees an enable on every cycle. A write in CTL_RUN returns the machine to CTL_LOAD.

Top module: `adc_tick_gen`

## Requirements
- R1: After reset, conv_en, tick_10us and tick_ms are low and cfg_rdata reads 0. No output pulses until the first write.
- R2: A write (cfg_we high at a clock edge) stores the conversion field from cfg_wdata[7:0], the 10 µs field from [15:8] and the millisecond field from [23:16]. From the next cycle, cfg_rdata returns these three fields in the same positions, with bits [31:24] reading zero whatever was written there.
- R3: With conversion field value F, conv_en pulses exactly once every F+1 parent cycles. F = 0 gives a pulse on every cycle.
- R4: Call the edge that samples a write cycle 0. All outputs are low in the cycle after that edge. Counting continues from zero, so the first conv_en pulse appears in cycle F+1. This holds for a write made while the block is already running.
- R5: With 10 µs field value T, tick_10us pulses on every (T+1)-th conv_en pulse, in the same cycle as that conv_en pulse.
- R6: With millisecond field value S, tick_ms pulses on every (S+1)-th tick_10us pulse, in the same cycle as that tick_10us pulse.
- R7: A millisecond field of 99 gives one tick_ms for every 100 tick_10us pulses. This includes the case where the conversion field is 0 and the divided clock equals the parent clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the divisor word |
| cfg_wdata | input | 32 | Divisor word to store |
| cfg_rdata | output | 32 | Stored divisor word, upper byte zero |
| conv_en | output | 1 | Conversion clock enable pulse |
| tick_10us | output | 1 | 10 µs timebase tick |
| tick_ms | output | 1 | Millisecond timebase tick |

## Verification
The assertions take three things for granted. cfg_we and cfg_wdata are synchronous to clk. A write can arrive on any cycle, including back to back or in the middle of a count. The divisor fields are used as written, with no check on range. The stimulus drives every input on the falling edge. It picks small random field values so that many tick_ms periods fit in a run. It writes random bytes into the unused upper byte, and at random points it rewrites the word while the block is running. Directed cases cover a ratio of one in every stage, the largest conversion ratio, and a millisecond ratio of one hundred.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

    localparam int FIELD_W    = 8;
    localparam int REG_W      = 32;
    localparam int NUM_STAGES = 3;
    localparam int USED_W     = FIELD_W * NUM_STAGES;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_LOAD = 2'd1,
        CTL_RUN  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/adc_tick_ctl.sv
module adc_tick_ctl
    import adc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_word,
    output logic             run,
    output logic             clr
);

    ctl_state_e              state_q;
    ctl_state_e              state_d;
    logic [USED_W-1:0]       word_q;

    // divisor word: only the packed fields are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cfg_we) begin
            word_q <= cfg_wdata[USED_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: if (cfg_we) state_d = CTL_LOAD;
            CTL_LOAD: state_d = cfg_we ? CTL_LOAD : CTL_RUN;
            CTL_RUN:  if (cfg_we) state_d = CTL_LOAD;
            default:  state_d = CTL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run      = (state_q == CTL_RUN);
        clr      = cfg_we;
        cfg_word = {{(REG_W-USED_W){1'b0}}, word_q};
    end

endmodule

// File: rtl/adc_tick_stage.sv
module adc_tick_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en_in,
    input  logic [W-1:0] ratio_m1,
    output logic         pulse_out
);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end    = (cnt_q == ratio_m1);
    assign pulse_out = en_in && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en_in) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             conv_en,
    output logic             tick_10us,
    output logic             tick_ms
);

    logic [REG_W-1:0]    word;
    logic                run;
    logic                clr;
    logic [NUM_STAGES:0] chain;

    adc_tick_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_word  (word),
        .run       (run),
        .clr       (clr)
    );

    assign chain[0] = run;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        adc_tick_stage #(.W(FIELD_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .en_in     (chain[g]),
            .ratio_m1  (word[g*FIELD_W +: FIELD_W]),
            .pulse_out (chain[g+1])
        );
    end

    assign cfg_rdata = word;
    assign conv_en   = chain[1];
    assign tick_10us = chain[2];
    assign tick_ms   = chain[3];

endmodule

// File: rtl/adc_tick_chk.sv
module adc_tick_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        conv_en,
    input logic        tick_10us,
    input logic        tick_ms
);

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == {8'h00, $past(cfg_wdata[23:0])});

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en && !cfg_we && cfg_rdata[7:0] != 8'd0) |=> !conv_en);

    assert_quiet_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!conv_en && !tick_10us && !tick_ms));

    assert_tick10_on_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_10us |-> conv_en);

    assert_tickms_on_tick10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_ms |-> tick_10us);

endmodule

bind adc_tick_gen adc_tick_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .conv_en   (conv_en),
    .tick_10us (tick_10us),
    .tick_ms   (tick_ms)
);

// File: tb/adc_tick_gen_tb.sv
module adc_tick_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        conv_en;
    logic        tick_10us;
    logic        tick_ms;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // bench model state
    bit          started = 0;
    int          c = 0;
    int          rn = 1, rm = 1, rp = 1;
    logic [31:0] rexp = '0;
    bit          dir7 = 0;

    always #5 clk = ~clk;

    adc_tick_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .conv_en   (conv_en),
        .tick_10us (tick_10us),
        .tick_ms   (tick_ms)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit exp_pulse(int period);
        return started && (c >= 1) && (c % period == 0);
    endfunction

    task automatic chk1(string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: c=%0d actual=%0b expected=%0b", tag, c, act, expv);
        end
    endtask

    task automatic check_now();
        string tconv, t10, tms;
        tconv = !started ? "R1" : (c <= rn ? "R4" : "R3");
        t10   = !started ? "R1" : "R5";
        tms   = !started ? "R1" : (dir7 ? "R7" : "R6");
        chk1(tconv, conv_en, exp_pulse(rn));
        chk1(t10, tick_10us, exp_pulse(rn * rm));
        chk1(tms, tick_ms, exp_pulse(rn * rm * rp));
        checks++;
        if (cfg_rdata !== rexp) begin
            failures++;
            $display("FAIL %s: readback actual=%h expected=%h", started ? "R2" : "R1", cfg_rdata, rexp);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd);
        @(negedge clk);
        check_now();
        cfg_we    = we;
        cfg_wdata = wd;
        @(posedge clk);
        if (we) begin
            started = 1;
            c    = 0;
            rn   = int'(wd[7:0]) + 1;
            rm   = int'(wd[15:8]) + 1;
            rp   = int'(wd[23:16]) + 1;
            rexp = {8'h00, wd[23:0]};
        end else begin
            c++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet and zero after reset, before any write
        idle(12);

        // R3 ratio of one in every stage
        step(1'b1, 32'hFF00_0000);
        idle(20);

        // R3 largest main ratio
        step(1'b1, 32'h0001_01FF);
        idle(1100);

        // R7 millisecond ratio of one hundred
        dir7 = 1;
        step(1'b1, 32'h0063_0100);
        idle(450);
        dir7 = 0;

        // R4 back-to-back writes
        step(1'b1, 32'h0000_0002);
        step(1'b1, 32'h0001_0203);
        idle(60);

        // random segments, writes land mid-count
        for (int s = 0; s < 60; s++) begin
            logic [31:0] w;
            w = {$urandom_range(255, 0), 8'($urandom_range(3, 0)),
                 8'($urandom_range(3, 0)), 8'($urandom_range(4, 0))};
            step(1'b1, w);
            idle($urandom_range(250, 5));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule